// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Checks

This block caches recent virtual-to-physical page translations for a processor's memory stage. A lookup presents a virtual address and an access kind (read, write or instruction fetch). In the same cycle the block reports exactly one of three outcomes. A hit returns the physical address. A miss means the translation must be fetched from the page tables. A fault means a cached translation exists but forbids this access. Pages are 8 KB, so the low 13 address bits pass through untouched, and the 19 bits above them are the page number that is looked up in every entry at once.

Each entry keeps a frame number, a translation-valid flag, a write-permit flag, a modified flag and a referenced flag. The block updates the last two itself as translations succeed. A miss handler installs translations through a valid/ready fill channel. The fill is accepted in any cycle where both `fill_valid` and `fill_ready` are high. `fill_ready` drops only while `flush` is asserted, and a producer facing a low `fill_ready` keeps its fill stable and retries. The lookup side has no back-pressure: `req_valid` is sampled every cycle and answered in that cycle. The hardware chooses where a fill goes, and an address-space switch empties the whole cache in one cycle through `flush`.

Top module: `page_xlat_cache`

## Requirements
- R1: After reset every entry is empty, the last-used pointer is entry 0, the captured fault address and mode are zero, and any lookup misses.
- R2: With `req_valid` high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high in that same cycle. With `req_valid` low, all three are low.
- R3: On a hit, `rsp_paddr` is the entry's frame number above `req_vaddr[12:0]`. In every other cycle `rsp_paddr` is zero.
- R4: A lookup whose page number (`req_vaddr[31:13]`) matches no held entry reports a miss. `rsp_dirty` and `rsp_refd` are then zero.
- R5: A lookup that matches an entry whose translation-valid flag is clear reports a fault for every access kind.
- R6: Access kind is encoded on `req_mode` as 0 for read, 1 for write and 2 for fetch. A write to a matching entry whose write-permit flag is clear faults. Reads and fetches through that entry succeed.
- R7: On a hit or fault, `rsp_dirty` and `rsp_refd` show the entry's stored flags before this access. A hit sets the referenced flag, and a write hit also sets the modified flag, both visible from the next cycle. A fault changes neither flag.
- R8: The cycle after a fault, `fault_vaddr` and `fault_mode` hold that lookup's address and kind. They keep those values until the next fault.
- R9: A fill is accepted when `fill_valid` and `fill_ready` are both high. `fill_ready` is low exactly while `flush` is high. An accepted entry answers lookups from the next cycle.
- R10: A fill whose page number is already held overwrites that entry in place, so no duplicate is created and no other entry is displaced.
- R11: A fill of a new page number goes to the lowest-numbered empty entry. If no entry is empty, it goes to the entry after the last-used one, wrapping from 47 to 0. The last-used pointer is the entry of the most recent hit, and fills do not move it.
- R12: `flush` empties all entries in one cycle, and lookups from the next cycle miss.
- R13: A fill stores the supplied translation-valid, write-permit, modified and referenced flags. If a hit on the same entry happens in the same cycle, the fill takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_mode | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| rsp_hit | output | 1 | Translation succeeded this cycle |
| rsp_miss | output | 1 | No entry held for the page |
| rsp_fault | output | 1 | Entry held but access refused |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |
| rsp_dirty | output | 1 | Stored modified flag of the matching entry |
| rsp_refd | output | 1 | Stored referenced flag of the matching entry |
| fault_vaddr | output | 32 | Address of the most recent fault |
| fault_mode | output | 2 | Access kind of the most recent fault |
| fill_valid | input | 1 | Fill offered |
| fill_ready | output | 1 | Fill can be accepted |
| fill_vpn | input | 19 | Page number being installed |
| fill_pfn | input | 19 | Frame number being installed |
| fill_pte_ok | input | 1 | Translation-valid flag for the fill |
| fill_wr_en | input | 1 | Write-permit flag for the fill |
| fill_dirty | input | 1 | Modified flag for the fill |
| fill_refd | input | 1 | Referenced flag for the fill |
| flush | input | 1 | Empty every entry |

## Verification
Directed passes separate the three outcomes by access kind against entries whose write-permit and translation-valid flags are clear. Repeated reads and writes show the flag updates that come from use, as distinct from the flags supplied by a fill. A full cache is then driven with a chosen last-used entry, including entry 47, to confirm the wrap. A refill of a held page confirms that an overwrite displaces no other entry, and a flush with a fill offered in the same cycle shows the refusal. A long seeded mix over 64 page numbers follows, with concurrent fills and lookups and occasional flushes. It tells the next-after-last-used victim apart from oldest-first or lowest-first schemes once the cache is full.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_mode_e;

  typedef struct packed {
    logic pte_ok;
    logic wr_en;
    logic dirty;
    logic refd;
  } ent_flags_t;

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 48,
  parameter int KEY_W   = 19,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            occ,
  input  logic [ENTRIES-1:0][KEY_W-1:0] tags,
  input  logic [KEY_W-1:0]              key,
  output logic                          any_hit,
  output logic [IDX_W-1:0]              hit_idx
);

  logic [ENTRIES-1:0] hitv;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitv[g] = occ[g] && (tags[g] == key);
  end

  assign any_hit = |hitv;

  // At most one line matches, so OR-ing indices encodes it.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitv[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 48,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] occ,
  input  logic [IDX_W-1:0]   last_used,
  output logic [IDX_W-1:0]   victim
);

  logic             has_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] after_last;

  // Lowest empty slot: scan downward so the smallest index is kept.
  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  assign after_last = (last_used == IDX_W'(ENTRIES - 1)) ? '0 : last_used + 1'b1;
  assign victim     = has_free ? free_idx : after_last;

endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 19,
  parameter int PFN_W   = 19,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          touch_en,
  input  logic [IDX_W-1:0]              touch_idx,
  input  logic                          touch_store,
  input  logic                          fill_en,
  input  logic [IDX_W-1:0]              fill_idx,
  input  logic [VPN_W-1:0]              fill_vpn,
  input  logic [PFN_W-1:0]              fill_pfn,
  input  ent_flags_t                    fill_flags,
  output logic [ENTRIES-1:0]            occ,
  output logic [ENTRIES-1:0][VPN_W-1:0] tags,
  output logic [ENTRIES-1:0][PFN_W-1:0] frames,
  output ent_flags_t [ENTRIES-1:0]      flags
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             occ_q;
    logic [VPN_W-1:0] tag_q;
    logic [PFN_W-1:0] pfn_q;
    ent_flags_t       flg_q;
    logic             fill_here;
    logic             touch_here;

    assign fill_here  = fill_en && (fill_idx == IDX_W'(g));
    assign touch_here = touch_en && (touch_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_q <= 1'b0;
        tag_q <= '0;
        pfn_q <= '0;
        flg_q <= '0;
      end else begin
        if (fill_here) begin
          tag_q <= fill_vpn;
          pfn_q <= fill_pfn;
          flg_q <= fill_flags;
        end else if (touch_here) begin
          flg_q.refd <= 1'b1;
          if (touch_store) flg_q.dirty <= 1'b1;
        end
        if (flush)          occ_q <= 1'b0;
        else if (fill_here) occ_q <= 1'b1;
      end
    end

    assign occ[g]    = occ_q;
    assign tags[g]   = tag_q;
    assign frames[g] = pfn_q;
    assign flags[g]  = flg_q;
  end

endmodule

// File: rtl/page_xlat_cache.sv
module page_xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 13,
  parameter int ENTRIES = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_mode,
  output logic                  rsp_hit,
  output logic                  rsp_miss,
  output logic                  rsp_fault,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic                  rsp_dirty,
  output logic                  rsp_refd,
  output logic [VA_W-1:0]       fault_vaddr,
  output logic [1:0]            fault_mode,
  input  logic                  fill_valid,
  output logic                  fill_ready,
  input  logic [VA_W-OFS_W-1:0] fill_vpn,
  input  logic [PA_W-OFS_W-1:0] fill_pfn,
  input  logic                  fill_pte_ok,
  input  logic                  fill_wr_en,
  input  logic                  fill_dirty,
  input  logic                  fill_refd,
  input  logic                  flush
);

  localparam int VPN_W = VA_W - OFS_W;
  localparam int PFN_W = PA_W - OFS_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]            occ;
  logic [ENTRIES-1:0][VPN_W-1:0] tags;
  logic [ENTRIES-1:0][PFN_W-1:0] frames;
  ent_flags_t [ENTRIES-1:0]      flags;

  logic [VPN_W-1:0] req_vpn;
  acc_mode_e        mode;
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;
  logic             fl_any;
  logic [IDX_W-1:0] fl_idx;
  logic [IDX_W-1:0] victim;
  logic [IDX_W-1:0] last_used_q;
  ent_flags_t       sel;
  logic             denied;
  logic             fill_en;
  logic [IDX_W-1:0] fill_idx;
  ent_flags_t       fill_flags;

  assign req_vpn = req_vaddr[VA_W-1:OFS_W];
  assign mode    = acc_mode_e'(req_mode);

  xlat_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
    .occ(occ), .tags(tags), .key(req_vpn), .any_hit(lk_any), .hit_idx(lk_idx)
  );

  xlat_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_fill_match (
    .occ(occ), .tags(tags), .key(fill_vpn), .any_hit(fl_any), .hit_idx(fl_idx)
  );

  xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .occ(occ), .last_used(last_used_q), .victim(victim)
  );

  // Lookup outcome
  assign sel       = flags[lk_idx];
  assign denied    = !sel.pte_ok || ((mode == ACC_WRITE) && !sel.wr_en);
  assign rsp_hit   = req_valid && lk_any && !denied;
  assign rsp_fault = req_valid && lk_any && denied;
  assign rsp_miss  = req_valid && !lk_any;
  assign rsp_paddr = rsp_hit ? {frames[lk_idx], req_vaddr[OFS_W-1:0]} : '0;
  assign rsp_dirty = req_valid && lk_any && sel.dirty;
  assign rsp_refd  = req_valid && lk_any && sel.refd;

  // Fill channel
  assign fill_ready = !flush;
  assign fill_en    = fill_valid && fill_ready;
  assign fill_idx   = fl_any ? fl_idx : victim;
  assign fill_flags = '{pte_ok: fill_pte_ok, wr_en: fill_wr_en,
                        dirty: fill_dirty, refd: fill_refd};

  xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .touch_en(rsp_hit), .touch_idx(lk_idx), .touch_store(mode == ACC_WRITE),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_flags(fill_flags),
    .occ(occ), .tags(tags), .frames(frames), .flags(flags)
  );

  // Replacement pointer and fault capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_used_q <= '0;
      fault_vaddr <= '0;
      fault_mode  <= '0;
    end else begin
      if (rsp_hit) last_used_q <= lk_idx;
      if (rsp_fault) begin
        fault_vaddr <= req_vaddr;
        fault_mode  <= req_mode;
      end
    end
  end

endmodule

// File: rtl/page_xlat_cache_chk.sv
module page_xlat_cache_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFS_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic [1:0]      req_mode,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_dirty,
  input logic            rsp_refd,
  input logic [VA_W-1:0] fault_vaddr,
  input logic [1:0]      fault_mode,
  input logic            fill_ready,
  input logic            flush
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1); // R2

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(rsp_hit || rsp_miss || rsp_fault)); // R2

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[OFS_W-1:0] == req_vaddr[OFS_W-1:0]); // R3

  AST_NO_ADDR_OFF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_paddr == '0); // R3

  AST_MISS_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> !rsp_dirty && !rsp_refd); // R4

  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |=> (fault_vaddr == $past(req_vaddr)) && (fault_mode == $past(req_mode))); // R8

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |=> $stable(fault_vaddr) && $stable(fault_mode)); // R8

  AST_FLUSH_BLOCKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fill_ready); // R9

endmodule

bind page_xlat_cache page_xlat_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_mode(req_mode), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty),
  .rsp_refd(rsp_refd), .fault_vaddr(fault_vaddr), .fault_mode(fault_mode),
  .fill_ready(fill_ready), .flush(flush)
);

// File: tb/page_xlat_cache_test.sv
`timescale 1ns/1ps
module page_xlat_cache_test;

  localparam int N = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_mode = '0;
  logic        rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_refd, fill_ready;
  logic [31:0] rsp_paddr, fault_vaddr;
  logic [1:0]  fault_mode;
  logic        fill_valid = 1'b0;
  logic [18:0] fill_vpn = '0;
  logic [18:0] fill_pfn = '0;
  logic        fill_pte_ok = 1'b0, fill_wr_en = 1'b0, fill_dirty = 1'b0, fill_refd = 1'b0;
  logic        flush = 1'b0;

  always #2 clk = ~clk;

  page_xlat_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_mode(req_mode), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty),
    .rsp_refd(rsp_refd), .fault_vaddr(fault_vaddr), .fault_mode(fault_mode),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_pte_ok(fill_pte_ok), .fill_wr_en(fill_wr_en),
    .fill_dirty(fill_dirty), .fill_refd(fill_refd), .flush(flush)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";

  // Behavioural reference model
  bit          m_occ [N];
  logic [18:0] m_vpn [N];
  logic [18:0] m_pfn [N];
  bit          m_ok [N], m_we [N], m_d [N], m_r [N];
  int          m_last = 0;
  logic [31:0] m_fva = '0;
  logic [1:0]  m_fmode = '0;

  function automatic int find(logic [18:0] k);
    for (int i = 0; i < N; i++) if (m_occ[i] && m_vpn[i] == k) return i;
    return -1;
  endfunction

  function automatic int pick_victim();
    for (int i = 0; i < N; i++) if (!m_occ[i]) return i;
    return (m_last + 1) % N;
  endfunction

  task automatic step();
    int li, fi;
    bit e_hit, e_miss, e_fault, e_d, e_r;
    logic [31:0] e_pa;
    logic [71:0] got, exp_v;
    #1;
    e_hit = 0; e_miss = 0; e_fault = 0; e_d = 0; e_r = 0; e_pa = '0;
    li = find(req_vaddr[31:13]);
    if (req_valid) begin
      if (li < 0) e_miss = 1;
      else begin
        e_fault = !m_ok[li] || (req_mode == 2'd1 && !m_we[li]);
        e_hit   = !e_fault;
        e_d     = m_d[li];
        e_r     = m_r[li];
        if (e_hit) e_pa = {m_pfn[li], req_vaddr[12:0]};
      end
    end
    got   = {rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_refd, fill_ready,
             rsp_paddr, fault_vaddr, fault_mode};
    exp_v = {e_hit, e_miss, e_fault, e_d, e_r, !flush, e_pa, m_fva, m_fmode};
    checks++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp_v);
    end
    @(posedge clk);
    fi = -1;
    if (fill_valid && !flush) begin
      fi = find(fill_vpn);
      if (fi < 0) fi = pick_victim();
    end
    if (e_hit) begin
      m_r[li] = 1;
      if (req_mode == 2'd1) m_d[li] = 1;
      m_last = li;
    end
    if (e_fault) begin
      m_fva = req_vaddr;
      m_fmode = req_mode;
    end
    if (fi >= 0) begin
      m_occ[fi] = 1; m_vpn[fi] = fill_vpn; m_pfn[fi] = fill_pfn;
      m_ok[fi] = fill_pte_ok; m_we[fi] = fill_wr_en;
      m_d[fi] = fill_dirty; m_r[fi] = fill_refd;
    end
    if (flush) for (int i = 0; i < N; i++) m_occ[i] = 0;
    @(negedge clk);
  endtask

  task automatic quiet();
    req_valid = 0; fill_valid = 0; flush = 0;
  endtask

  task automatic look(logic [18:0] vpn, logic [12:0] ofs, logic [1:0] md);
    req_valid = 1; req_vaddr = {vpn, ofs}; req_mode = md;
    step();
    quiet();
  endtask

  task automatic put(logic [18:0] vpn, logic [18:0] pfn, bit ok, bit we, bit d, bit r);
    fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn;
    fill_pte_ok = ok; fill_wr_en = we; fill_dirty = d; fill_refd = r;
    step();
    quiet();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_occ[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0;
      m_ok[i] = 0; m_we[i] = 0; m_d[i] = 0; m_r[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    tag = "R1"; step(); look(19'h12345, 13'h0abc, 2'd0);
    tag = "R2"; step();

    tag = "R9"; put(19'h00011, 19'h7aaaa, 1, 1, 0, 0);
    tag = "R3"; look(19'h00011, 13'h1fff, 2'd0); look(19'h00011, 13'h0001, 2'd2);
    tag = "R7"; look(19'h00011, 13'h0010, 2'd1); look(19'h00011, 13'h0010, 2'd0);
    tag = "R4"; look(19'h00012, 13'h0000, 2'd1);

    tag = "R6"; put(19'h00020, 19'h01234, 1, 0, 0, 0);
    look(19'h00020, 13'h0444, 2'd1); look(19'h00020, 13'h0444, 2'd0);
    look(19'h00020, 13'h0555, 2'd2);
    tag = "R8"; step(); step(); look(19'h00020, 13'h0999, 2'd1);

    tag = "R5"; put(19'h00030, 19'h04321, 0, 1, 0, 0);
    look(19'h00030, 13'h0001, 2'd0); look(19'h00030, 13'h0002, 2'd2);
    look(19'h00030, 13'h0003, 2'd1);

    tag = "R13"; put(19'h00040, 19'h05555, 1, 1, 1, 1);
    look(19'h00040, 13'h0042, 2'd0);
    // fill and hit on the same entry together: fill wins
    req_valid = 1; req_vaddr = {19'h00040, 13'h0}; req_mode = 2'd1;
    fill_valid = 1; fill_vpn = 19'h00040; fill_pfn = 19'h06666;
    fill_pte_ok = 1; fill_wr_en = 1; fill_dirty = 0; fill_refd = 0;
    step(); quiet();
    look(19'h00040, 13'h0042, 2'd0);

    tag = "R12"; flush = 1; fill_valid = 1; fill_vpn = 19'h00050; step(); quiet();
    look(19'h00011, 13'h0, 2'd0); look(19'h00050, 13'h0, 2'd0);

    tag = "R11";
    for (int i = 0; i < N; i++) put(19'h00100 + 19'(i), 19'h10000 + 19'(i), 1, 1, 0, 0);
    look(19'h0010a, 13'h0, 2'd0);
    put(19'h00200, 19'h20000, 1, 1, 0, 0);
    look(19'h0010b, 13'h0, 2'd0); look(19'h00200, 13'h0, 2'd0);
    look(19'h0012f, 13'h0, 2'd0);
    put(19'h00201, 19'h20001, 1, 1, 0, 0);
    look(19'h00100, 13'h0, 2'd0); look(19'h00201, 13'h0, 2'd0);

    tag = "R10";
    put(19'h00105, 19'h3abcd, 1, 1, 0, 0);
    look(19'h00105, 13'h0123, 2'd0);
    put(19'h00202, 19'h20002, 1, 1, 0, 0);
    for (int i = 0; i < N; i++) look(19'h00100 + 19'(i), 13'h0, 2'd2);

    tag = "R11";
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 10) begin
        req_valid = 1;
        req_vaddr = {19'($urandom % 64), 13'($urandom)};
        req_mode = 2'($urandom % 3);
      end
      if (r >= 6 && r != 15) begin
        fill_valid = 1; fill_vpn = 19'($urandom % 64); fill_pfn = 19'($urandom);
        fill_pte_ok = ($urandom % 8) != 0; fill_wr_en = ($urandom % 2) != 0;
        fill_dirty = ($urandom % 2) != 0; fill_refd = ($urandom % 2) != 0;
      end
      if (r == 15 && ($urandom % 4) == 0) flush = 1;
      step();
      quiet();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL R2 watchdog: got still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule